// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that can take a new read or write on every clock, with no idle slots when reads and writes mix. Address and control are registered on the rising edge. The data belonging to a command crosses the bus in a fixed slot: write data is sampled two enabled clocks after its command. Read data is driven during the cycle that ends at the second enabled clock after its command. Because reads and writes use the same slot, a read followed by a write, or a write followed by a read, never competes for the bus.

Pending write addresses travel through two registers until their data arrives. A read that lands while an older write to the same word is still waiting for its data takes the waiting bytes straight from the data bus. It takes the remaining bytes from the array.

Each word is split into byte lanes of 9 bits (8 data and 1 parity), and each lane has its own write select. Three chip selects, a clock enable that freezes the whole block, an asynchronous output enable and a sleep input complete the interface. The drive-enable output stands in for the three-state control of a shared data bus.

Top module: `lw_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dq_drive` is 0 and `rd_data` is 0 until the first read has been loaded.
- R2: A read accepted at enabled edge k presents the word on `rd_data`, with `dq_drive` high, from enabled edge k+1 until enabled edge k+2.
- R3: The data of a write accepted at enabled edge k is sampled from `wdata` at enabled edge k+2.
- R4: Reads and writes may follow one another on consecutive enabled edges in any order, and every read returns the value left by all writes accepted before it.
- R5: Lane i occupies bits [9i+8:9i] and is written only when `byte_en[i]` is 1; lanes whose select is 0 keep their contents.
- R6: A read accepted one enabled edge after a write to the same address returns the pending write data for the lanes that write selects, and the stored value for the others.
- R7: An edge where `clk_en` is 0 is ignored: no write takes place, no command is accepted, and `rd_data` and `dq_drive` hold.
- R8: `dq_drive` is 0 during the data slot of every write, whatever `out_en` is.
- R9: A command is accepted only when `chip_sel_a` is 1, `chip_sel_b` is 1 and `chip_sel_c_n` is 0; otherwise the edge is a no-op that writes nothing and drives nothing.
- R10: While `sleep` is 1, commands are ignored and `dq_drive` is 0, and `dq_drive` is still 0 in the first cycle after `sleep` falls. Sleep is entered only while the block is deselected.
- R11: `out_en` acts on `dq_drive` at once and without a clock, and it changes neither `rd_data` nor the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and output stage |
| clk_en | input | 1 | 1 = act on this edge, 0 = ignore it |
| chip_sel_a | input | 1 | Chip select, active high |
| chip_sel_b | input | 1 | Chip select, active high |
| chip_sel_c_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| byte_en | input | LANES | Per-lane write selects |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep request |
| rd_data | output | LANES*LANE_W | Registered read data |
| dq_drive | output | 1 | 1 when the block drives the data bus |

## Verification
The assertions assume a controller that raises `sleep` only while at least one chip select is inactive. The stimulus always deasserts a select on the same negative edge on which it raises `sleep`, and asserts selects again only once `sleep` is high. The property on write slots counts on the bus arbitration that late write gives. The bench puts each write's data on `wdata` exactly two enabled edges after its command, including across edges that `clk_en` suppresses. It reads back only addresses it has written, so no check depends on the array's power-up contents.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2
   } op_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              sleep,
   input  logic              cs_a,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  be,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output op_e               s2_op,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_be
);

   logic             picked;
   op_e              op_in;
   logic [LANES-1:0] s1_be;

   assign picked = cs_a & cs_b & ~cs_c_n;

   always_comb begin
      op_in = OP_NOP;
      if (picked && !sleep) op_in = wr ? OP_WR : OP_RD;
   end

   // stage 1: freshly accepted command; stage 2: write waiting for its data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op   <= OP_NOP;
         s1_addr <= '0;
         s1_be   <= '0;
         s2_op   <= OP_NOP;
         s2_addr <= '0;
         s2_be   <= '0;
      end else if (ce) begin
         s1_op   <= op_in;
         s1_addr <= addr;
         s1_be   <= be;
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   p_desel_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !picked) |=> (s1_op == OP_NOP));

   p_sleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep) |-> !picked);

   p_addr_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> (s2_addr == $past(s1_addr)));

endmodule

// File: rtl/lw_sram_lane.sv
module lw_sram_lane #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              ce,
   input  logic              pend_wr,
   input  logic [ADDR_W-1:0] pend_addr,
   input  logic [LANE_W-1:0] bus_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_lane
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];
   logic              hit;

   always_ff @(posedge clk) begin
      if (ce && pend_wr) mem[pend_addr] <= bus_data;
   end

   // coherency bypass: the waiting write's bytes win over the stale array word
   assign hit     = pend_wr && (pend_addr == rd_addr);
   assign rd_lane = hit ? bus_data : mem[rd_addr];

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              sleep,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              oe,
   output logic [DATA_W-1:0] dout,
   output logic              drive
);

   logic [DATA_W-1:0] q;
   logic              drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         drv_q <= 1'b0;
      end else begin
         if (ce && load) q <= din;
         if (sleep)      drv_q <= 1'b0;
         else if (ce)    drv_q <= load;
      end
   end

   assign dout  = q;
   assign drive = oe & drv_q & ~sleep;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en,
   input  logic                      chip_sel_a,
   input  logic                      chip_sel_b,
   input  logic                      chip_sel_c_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES-1:0]          byte_en,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      out_en,
   input  logic                      sleep,
   output logic [LANES*LANE_W-1:0]   rd_data,
   output logic                      dq_drive
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("lw_sram: ADDR_W must lie in 1..12");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("lw_sram: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("lw_sram: LANE_W must be at least 1");
   end

   op_e               s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s2_be;
   logic [DATA_W-1:0] rd_mix;

   lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce      (clk_en),
      .sleep   (sleep),
      .cs_a    (chip_sel_a),
      .cs_b    (chip_sel_b),
      .cs_c_n  (chip_sel_c_n),
      .wr      (wr_en),
      .addr    (addr),
      .be      (byte_en),
      .s1_op   (s1_op),
      .s1_addr (s1_addr),
      .s2_op   (s2_op),
      .s2_addr (s2_addr),
      .s2_be   (s2_be)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lw_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk       (clk),
         .ce        (clk_en),
         .pend_wr   ((s2_op == OP_WR) && s2_be[i]),
         .pend_addr (s2_addr),
         .bus_data  (wdata[i*LANE_W +: LANE_W]),
         .rd_addr   (s1_addr),
         .rd_lane   (rd_mix[i*LANE_W +: LANE_W])
      );
   end

   lw_sram_out #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (clk_en),
      .sleep (sleep),
      .load  (s1_op == OP_RD),
      .din   (rd_mix),
      .oe    (out_en),
      .dout  (rd_data),
      .drive (dq_drive)
   );

   p_write_slot_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_op == OP_WR) |-> !dq_drive);

   p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(rd_data));

   p_sleep_exit_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> !dq_drive);

   p_read_slot_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !sleep && out_en && s1_op == OP_RD) |=> (dq_drive || !out_en || sleep));

endmodule

// File: tb/lw_sram_tb.sv
module lw_sram_tb;

   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int NV = 16;

   // entry: [47:46] op (0 nop, 1 read, 2 write), [45:40] addr, [39:36] lanes, [35:0] data
   localparam logic [47:0] VEC [NV] = '{
      {2'd2, 6'd1, 4'hF, 36'h123456789},
      {2'd2, 6'd2, 4'hF, 36'h987654321},
      {2'd1, 6'd1, 4'h0, 36'h0},
      {2'd2, 6'd3, 4'hF, 36'h0AAAA5555},
      {2'd1, 6'd2, 4'h0, 36'h0},
      {2'd1, 6'd3, 4'h0, 36'h0},
      {2'd2, 6'd1, 4'h5, 36'hFFFFFFFFF},
      {2'd1, 6'd1, 4'h0, 36'h0},
      {2'd2, 6'd4, 4'hF, 36'h5A5A5A5A5},
      {2'd1, 6'd4, 4'h0, 36'h0},
      {2'd0, 6'd0, 4'h0, 36'h0},
      {2'd2, 6'd2, 4'h8, 36'h000000000},
      {2'd1, 6'd2, 4'h0, 36'h0},
      {2'd1, 6'd1, 4'h0, 36'h0},
      {2'd2, 6'd7, 4'hF, 36'h333333333},
      {2'd1, 6'd7, 4'h0, 36'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n, clk_en, cs_a, cs_b, cs_c_n, wr_en, out_en, sleep;
   logic [AW-1:0] addr;
   logic [NL-1:0] byte_en;
   logic [DW-1:0] wdata, rd_data;
   logic          dq_drive;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [DW-1:0] model [1<<AW];
   logic [DW-1:0] expq  [NV+2];
   logic          isrd  [NV+2];

   always #10 clk = ~clk;

   lw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_a(cs_a), .chip_sel_b(cs_b),
      .chip_sel_c_n(cs_c_n), .wr_en(wr_en), .addr(addr), .byte_en(byte_en), .wdata(wdata),
      .out_en(out_en), .sleep(sleep), .rd_data(rd_data), .dq_drive(dq_drive)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input int op, input int a, input logic [NL-1:0] b);
      cs_a    = (op != 0);
      cs_b    = 1'b1;
      cs_c_n  = 1'b0;
      wr_en   = (op == 2);
      addr    = AW'(a);
      byte_en = b;
   endtask

   task automatic model_wr(input int a, input logic [NL-1:0] b, input logic [DW-1:0] d);
      for (int l = 0; l < NL; l++)
         if (b[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         done = 1;
         summary();
      end
   end

   initial begin
      rst_n = 0; clk_en = 1; out_en = 1; sleep = 0; wdata = '0;
      cmd(0, 0, '0);
      repeat (3) @(negedge clk);
      chk("R1 drive in reset", {35'd0, dq_drive}, '0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 drive after reset", {35'd0, dq_drive}, '0);
      chk("R1 data after reset", rd_data, '0);

      // table walk: check slot i-2, then apply command i and data of command i-2
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            if (isrd[i-2]) begin
               chk("R2 R4 R6 read drive", {35'd0, dq_drive}, {35'd0, 1'b1});
               chk("R2 R4 R5 R6 read data", rd_data, expq[i-2]);
            end else begin
               chk("R8 idle or write slot quiet", {35'd0, dq_drive}, '0);
            end
         end
         if (i < NV) begin
            cmd(int'(VEC[i][47:46]), int'(VEC[i][45:40]), VEC[i][39:36]);
            isrd[i] = (VEC[i][47:46] == 2'd1);
            if (VEC[i][47:46] == 2'd2) model_wr(int'(VEC[i][45:40]), VEC[i][39:36], VEC[i][35:0]);
            expq[i] = model[VEC[i][45:40]];
         end else begin
            cmd(0, 0, '0);
         end
         if (i >= 2 && VEC[i-2][47:46] == 2'd2) wdata = VEC[i-2][35:0];
         else wdata = '0;
      end

      // R7: suppressed edge neither samples write data nor moves the pipeline
      @(negedge clk); cmd(2, 9, 4'hF);
      @(negedge clk); cmd(0, 0, '0);
      @(negedge clk); clk_en = 0; wdata = 36'h0DEADBEEF;
      @(negedge clk); clk_en = 1; wdata = 36'h111111111;
      @(negedge clk); cmd(1, 9, '0); wdata = '0;
      @(negedge clk); cmd(0, 0, '0);
      @(negedge clk);
      chk("R7 R3 data after stalled write", rd_data, 36'h111111111);
      clk_en = 0; cmd(1, 1, '0);
      @(negedge clk);
      chk("R7 data held while disabled", rd_data, 36'h111111111);
      chk("R7 drive held while disabled", {35'd0, dq_drive}, {35'd0, 1'b1});
      clk_en = 1; cmd(0, 0, '0);
      @(negedge clk);
      chk("R7 read ignored while disabled", {35'd0, dq_drive}, '0);

      // R11: asynchronous output enable
      cmd(1, 9, '0);
      @(negedge clk); cmd(0, 0, '0);
      @(negedge clk);
      chk("R11 drive with oe", {35'd0, dq_drive}, {35'd0, 1'b1});
      out_en = 0; #1;
      chk("R11 drive drops at once", {35'd0, dq_drive}, '0);
      chk("R11 data unchanged", rd_data, 36'h111111111);
      out_en = 1; #1;
      chk("R11 drive returns", {35'd0, dq_drive}, {35'd0, 1'b1});

      // R9: each chip select on its own deselects
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); cmd(2, 9, 4'hF);
         if (k == 0) cs_a = 0; else if (k == 1) cs_b = 0; else cs_c_n = 1;
         @(negedge clk); cmd(1, 9, '0);
         if (k == 0) cs_a = 0; else if (k == 1) cs_b = 0; else cs_c_n = 1;
         @(negedge clk); cmd(0, 0, '0); wdata = '0;
         @(negedge clk);
         chk("R9 deselected read not driven", {35'd0, dq_drive}, '0);
         cmd(1, 9, '0);
         @(negedge clk); cmd(0, 0, '0);
         @(negedge clk);
         chk("R9 deselected write ignored", rd_data, 36'h111111111);
      end

      // R10: sleep
      @(negedge clk); cmd(0, 0, '0); sleep = 1;
      @(negedge clk);
      chk("R10 drive off in sleep", {35'd0, dq_drive}, '0);
      cmd(2, 9, 4'hF);
      @(negedge clk); cmd(1, 9, '0);
      @(negedge clk); cmd(0, 0, '0); wdata = '0;
      @(negedge clk);
      chk("R10 read ignored in sleep", {35'd0, dq_drive}, '0);
      sleep = 0;
      @(negedge clk);
      chk("R10 drive off after wake", {35'd0, dq_drive}, '0);
      cmd(1, 9, '0);
      @(negedge clk); cmd(0, 0, '0);
      @(negedge clk);
      chk("R10 write ignored in sleep", rd_data, 36'h111111111);
      chk("R10 read after wake driven", {35'd0, dq_drive}, {35'd0, 1'b1});

      @(negedge clk);
      done = 1;
      summary();
   end

endmodule